// File: doc/BRIEF.md
# APB Requester

This block sits between a simple local request port and an APB bus and acts as the bus requester. A local agent raises `reqValid` together with an address, a direction flag and write data. The block then runs the APB handshake on its own. It spends one cycle in a setup phase with the select line high and enable low. It then enters an access phase with both lines high and stays there until the completer signals `busReady`.

Address, direction and write data are sampled into registers at the moment a transfer is accepted. The bus therefore sees fixed values for the whole transfer, whatever the local side does in the meantime.

Completion is reported on `rspDone` in the cycle where the completer answers. `rspErr` carries the completer's error flag in that same cycle, and `rspData` shows the read data. If `reqValid` is still high when a transfer completes, the next transfer starts with no idle cycle in between.

Top module: `apb_requester`

## Requirements
- R1: `rstN` is an asynchronous, active-low reset. While it is low, `busSel`, `busEnable`, `rspDone` and `rspErr` are 0 and `rspData` is 0.
- R2: From idle (`busSel`=0, `busEnable`=0), a high `reqValid` at a clock edge starts a transfer. In the following cycle the block is in the setup phase: `busSel`=1 and `busEnable`=0.
- R3: The setup phase lasts exactly one cycle. It is always followed by the access phase, in which `busSel`=1 and `busEnable`=1.
- R4: The access phase repeats for every cycle in which `busReady` is 0 (wait states).
- R5: An access cycle with `busReady`=1 and `reqValid`=0 completes the transfer. The next cycle is idle.
- R6: An access cycle with `busReady`=1 and `reqValid`=1 completes the transfer. The next cycle is the setup phase of a new transfer, with no idle cycle between the two.
- R7: `reqAddr`, `reqWrite` and `reqWdata` are registered at the edge that enters setup. `busAddr`, `busWrite` and `busWdata` show those values from setup through the last access cycle. Changes on the request inputs during a transfer have no effect on them.
- R8: On a read (`busWrite`=0), `rspData` equals `busRdata` in the completion cycle and keeps that value until the next read completes. Completing a write, and `busRdata` during a write, leave `rspData` unchanged.
- R9: `rspDone` is 1 in exactly the completion cycle of each transfer and 0 in every other cycle.
- R10: `rspErr` equals `busErr` in the completion cycle and is 0 otherwise. An error does not prevent or delay completion.
- R11: Each transfer takes at least two cycles: `busEnable` is never 1 in the first cycle in which `busSel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Local request for a transfer |
| reqAddr | input | ADDR_W | Local transfer address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Local write data |
| rspData | output | DATA_W | Read data, held until the next read completes |
| rspDone | output | 1 | High in the completion cycle |
| rspErr | output | 1 | Completer error, valid with rspDone |
| busSel | output | 1 | Bus select |
| busEnable | output | 1 | Bus access-phase enable |
| busAddr | output | ADDR_W | Bus address |
| busWrite | output | 1 | Bus direction |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data from the completer |
| busReady | input | 1 | Completer ready, ends the access phase |
| busErr | input | 1 | Completer error flag |

## Verification
Two things can fall on the same clock edge: a completing read must move `busRdata` into the held read register, and the register bank must accept the next request's address, direction and data. The bench provokes this with a stretch in which `reqValid` and `busReady` stay high while the request fields and read data change every cycle.

In that stretch, each completion should be followed at once by a setup phase that carries the new fields. `rspData` should still return the read value of the transfer that has just finished. A second stretch with rare `busReady` stirs the request inputs during long wait phases to show that the bus fields stay fixed.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // register a new request this edge
    logic finish; // current cycle completes the transfer
  } ctrlStrobes_t;

endpackage

// File: rtl/apb_req_ctrl.sv
module apb_req_ctrl
  import apb_req_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         busReady,
  output logic         busSel,
  output logic         busEnable,
  output ctrlStrobes_t strobes
);

  phase_t phase;
  phase_t phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext      = phase;
    strobes.load   = 1'b0;
    strobes.finish = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNext    = PH_SETUP;
          strobes.load = 1'b1;
        end
      end
      PH_SETUP: phaseNext = PH_ACCESS;
      PH_ACCESS: begin
        if (busReady) begin
          strobes.finish = 1'b1;
          if (reqValid) begin
            phaseNext    = PH_SETUP;
            strobes.load = 1'b1;
          end else begin
            phaseNext = PH_IDLE;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign busSel    = (phase != PH_IDLE);
  assign busEnable = (phase == PH_ACCESS);

endmodule

// File: rtl/apb_req_dpath.sv
module apb_req_dpath
  import apb_req_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busErr,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic              rspErr
);

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              readFinish;

  assign readFinish = strobes.finish && !writeQ;

  // request fields, frozen for the life of a transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strobes.load) begin
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
    end
  end

  // read data holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdataQ <= '0;
    else if (readFinish) rdataQ <= busRdata;
  end

  assign busAddr  = addrQ;
  assign busWrite = writeQ;
  assign busWdata = wdataQ;
  assign rspData  = readFinish ? busRdata : rdataQ;
  assign rspDone  = strobes.finish;
  assign rspErr   = strobes.finish && busErr;

endmodule

// File: rtl/apb_requester.sv
module apb_requester
  import apb_req_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic              rspErr,
  output logic              busSel,
  output logic              busEnable,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  input  logic              busErr
);

  ctrlStrobes_t strobes;

  apb_req_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .busReady  (busReady),
    .busSel    (busSel),
    .busEnable (busEnable),
    .strobes   (strobes)
  );

  apb_req_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .busRdata (busRdata),
    .busErr   (busErr),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .rspData  (rspData),
    .rspDone  (rspDone),
    .rspErr   (rspErr)
  );

endmodule

// File: rtl/apb_requester_chk.sv
module apb_requester_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busSel,
  input logic              busEnable,
  input logic              busReady,
  input logic              busErr,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              rspDone,
  input logic              rspErr,
  input logic [DATA_W-1:0] rspData
);

  a_r11_first_cycle_no_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busSel) |-> !busEnable);

  a_r3_setup_then_access: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busEnable) |=> (busSel && busEnable));

  a_r4_wait_keeps_access: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && !busReady) |=> (busSel && busEnable));

  a_r5_finish_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && busReady && !reqValid) |=> !busSel);

  a_r6_finish_to_setup: assert property (@(posedge clk) disable iff (!rstN)
    (busEnable && busReady && reqValid) |=> (busSel && !busEnable));

  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !(busEnable && busReady)) |=>
      ($stable(busAddr) && $stable(busWrite) && $stable(busWdata)));

  a_r8_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone && !busWrite) |=> (rspData == $past(busRdata)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspDone && busErr));

endmodule

bind apb_requester apb_requester_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (.*);

// File: tb/sim_apb_requester.sv
`timescale 1ns/1ps
module sim_apb_requester;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CYCLES = 4000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqWrite = 1'b0;
  logic [DW-1:0] reqWdata = '0;
  logic [DW-1:0] rspData;
  logic          rspDone;
  logic          rspErr;
  logic          busSel;
  logic          busEnable;
  logic [AW-1:0] busAddr;
  logic          busWrite;
  logic [DW-1:0] busWdata;
  logic [DW-1:0] busRdata = '0;
  logic          busReady = 1'b0;
  logic          busErr = 1'b0;

  always #2 clk = ~clk;

  apb_requester #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference state: 0 idle, 1 setup, 2 access
  int            mPh;
  bit            mFromAccess;
  bit            mWaited;
  logic [AW-1:0] mAddr;
  logic          mWr;
  logic [DW-1:0] mWd;
  logic [DW-1:0] mRd;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] expData(input int ph, input logic ready,
                                            input logic wr, input logic [DW-1:0] rd,
                                            input logic [DW-1:0] held);
    return (ph == 2 && ready && !wr) ? rd : held;
  endfunction

  function automatic string phaseTag(input int ph, input bit fromAcc, input bit waited);
    if (ph == 0) return "R5 idle";
    if (ph == 1) return fromAcc ? "R6 chained setup" : "R2 setup";
    return waited ? "R4 wait access" : "R3 access";
  endfunction

  task automatic modelReset();
    mPh = 0; mFromAccess = 0; mWaited = 0;
    mAddr = '0; mWr = 1'b0; mWd = '0; mRd = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset sel", busSel, 0);
    chk("R1 reset enable", busEnable, 0);
    chk("R1 reset done", rspDone, 0);
    chk("R1 reset data", rspData, 0);
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(negedge clk);
      if (cyc % 700 == 350) begin
        rstN = 1'b0;
        #1;
        chk("R1 async reset sel", busSel, 0);
        chk("R1 async reset enable", busEnable, 0);
        chk("R1 async reset done", rspDone, 0);
        chk("R1 async reset err", rspErr, 0);
        chk("R1 async reset data", rspData, 0);
        modelReset();
        continue;
      end
      rstN = 1'b1;
      reqAddr  = $urandom;
      reqWrite = $urandom_range(0, 1);
      reqWdata = $urandom;
      busRdata = $urandom;
      busErr   = ($urandom_range(0, 9) < 3);
      if (cyc >= 400 && cyc < 800) begin
        // chained transfers: request and ready always high
        reqValid = 1'b1;
        busReady = 1'b1;
      end else if (cyc >= 800 && cyc < 1200) begin
        // long wait phases with request inputs churning
        reqValid = $urandom_range(0, 1);
        busReady = ($urandom_range(0, 19) < 3);
      end else begin
        reqValid = $urandom_range(0, 1);
        busReady = ($urandom_range(0, 9) < 6);
      end
      #1;
      chk({phaseTag(mPh, mFromAccess, mWaited), " sel"}, busSel, mPh != 0);
      chk({phaseTag(mPh, mFromAccess, mWaited), " enable"}, busEnable, mPh == 2);
      if (mPh == 1) chk("R11 first cycle has no enable", busEnable, 0);
      chk("R9 done", rspDone, mPh == 2 && busReady);
      chk("R10 err", rspErr, mPh == 2 && busReady && busErr);
      chk("R8 read data", rspData, expData(mPh, busReady, mWr, busRdata, mRd));
      if (mPh != 0) begin
        chk("R7 addr", busAddr, mAddr);
        chk("R7 write", busWrite, mWr);
        chk("R7 wdata", busWdata, mWd);
      end
      // advance the reference to the next edge
      case (mPh)
        0: if (reqValid) begin
             mPh = 1; mFromAccess = 0;
             mAddr = reqAddr; mWr = reqWrite; mWd = reqWdata;
           end
        1: begin mPh = 2; mWaited = 0; end
        default: begin
          if (busReady) begin
            if (!mWr) mRd = busRdata;
            if (reqValid) begin
              mPh = 1; mFromAccess = 1;
              mAddr = reqAddr; mWr = reqWrite; mWd = reqWdata;
            end else begin
              mPh = 0;
            end
          end else begin
            mWaited = 1;
          end
        end
      endcase
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule